// File: doc/BRIEF.md
# Priority Pixel Dispatcher with Worker Pool

The block walks a small raster, one pixel coordinate at a time, and hands each coordinate to a pool of parallel compute units. Every unit takes a different, varying number of cycles per item. The dispatcher therefore does not wait on any one unit. In each cycle it offers the current coordinate to the free unit with the lowest index. If no unit is free, it drops its offer for one cycle and then tries again. The coordinate moves on only when a transfer completes. With enough units the pool takes close to one coordinate per clock.

Each unit reduces the coordinate it receives to a 2-bit pixel class. It holds that class, together with the coordinate it came from, on its result port until the consumer accepts it. A unit that still holds a result does not accept new work, so the consumer's acceptance signal sets which units are free.

The dispatcher has two states. `D_OFFER` drives the offer and moves to `D_SKIP` when no link is ready. It stays in `D_OFFER` after a transfer. `D_SKIP` drives no offer and always returns to `D_OFFER`. Each worker has three states. `W_IDLE` is ready and moves to `W_BUSY` when it accepts an item. `W_BUSY` counts down and moves to `W_DONE` when the count reaches zero. `W_DONE` presents the result and returns to `W_IDLE` once the result is accepted.

Top module: `pixel_dispatch_top`

## Requirements
- R1: The pool has NUM_WORKERS units (default 5). Each unit draws its latency, from the cycle its item is dispatched to the first cycle its result is valid, from a per-unit pseudo-random generator, and that latency lies between 3 and 5 cycles.
- R2: A transfer on a link happens only in a cycle where the dispatcher offers on that link and that unit is in its ready state. A unit is ready only when it is neither working nor holding a result.
- R3: At most one link carries an offer per cycle. The item goes to the lowest-index ready unit, and `disp_worker` gives that index in binary.
- R4: When the dispatcher offers and no unit is ready, it makes no offer in the next cycle, whatever the readiness then. In the cycle after that it offers again.
- R5: The coordinate changes only in a cycle with a transfer. x increments, and when x equals width minus one it returns to 0 and y increments in the same step.
- R6: After (3,3) the coordinate returns to (0,0). Over each 16-item frame every coordinate is dispatched exactly once, in raster order (x fastest).
- R7: The pixel class is 2 (binary 10) when bit 0 of both x and y is 0. It is 1 (binary 01) when both are 1. It is 3 (binary 11) otherwise. Unit i reports its class on `res_pix[2i+1:2i]` and its coordinate on `res_x`/`res_y` at the same position.
- R8: A valid result, with its class, stays unchanged until `res_ready` for that unit is high. The unit becomes ready again only in the cycle after the acceptance.
- R9: While `rst_n` is low the coordinate is (0,0) and no result is valid. In the first cycle after reset the dispatcher offers (0,0) to unit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| res_ready | input | NUM_WORKERS | Consumer accepts the result of unit i |
| disp_fire | output | 1 | A transfer completes at the coming edge |
| disp_worker | output | IDX_W | Index of the unit receiving the transfer |
| disp_x | output | XW | Current x coordinate |
| disp_y | output | YW | Current y coordinate |
| res_valid | output | NUM_WORKERS | Unit i holds a result |
| res_pix | output | 2*NUM_WORKERS | Pixel class per unit |
| res_x | output | XW*NUM_WORKERS | x of the result per unit |
| res_y | output | YW*NUM_WORKERS | y of the result per unit |

## Verification
The bench builds the block with its default parameters: five units, a 4 by 4 raster and latencies from 3 to 5. With these values a frame of 16 items wraps many times in one run, and all three pixel classes appear in each frame. Driving the five result-acceptance lines with fixed masks holds chosen units busy. This exposes lowest-index selection, the cycle dropped after a miss, and a pool that is fully stalled.

// File: rtl/pd_pkg.sv
package pd_pkg;

    localparam int PIX_W = 2;

    typedef enum logic [1:0] {W_IDLE, W_BUSY, W_DONE} wstate_e;
    typedef enum logic       {D_OFFER, D_SKIP}        dstate_e;

    // Pixel class from the low bits of the coordinate (R7)
    function automatic logic [PIX_W-1:0] pix_class(input logic xl, input logic yl);
        if (!xl && !yl)     return 2'd2;
        else if (xl && yl)  return 2'd1;
        else                return 2'd3;
    endfunction

endpackage

// File: rtl/pd_prio_pick.sv
module pd_prio_pick #(
    parameter int N     = 5,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        gnt = '0;
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                gnt[i] = 1'b1;
                any    = 1'b1;
                idx    = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pd_dispatcher.sv
module pd_dispatcher
    import pd_pkg::*;
#(
    parameter int N     = 5,
    parameter int SCR_W = 4,
    parameter int SCR_H = 4,
    parameter int XW    = 2,
    parameter int YW    = 2,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     link_ready,
    output logic [N-1:0]     link_valid,
    output logic             fire,
    output logic [IDX_W-1:0] widx,
    output logic [XW-1:0]    cur_x,
    output logic [YW-1:0]    cur_y
);

    localparam logic [XW-1:0] X_LAST = XW'(SCR_W - 1);
    localparam logic [YW-1:0] Y_LAST = YW'(SCR_H - 1);

    dstate_e      st, st_nx;
    logic         offering;
    logic [N-1:0] gnt;
    logic         any_rdy;

    pd_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .req (link_ready),
        .gnt (gnt),
        .any (any_rdy),
        .idx (widx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= D_OFFER;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            D_OFFER: if (!any_rdy) st_nx = D_SKIP;
            D_SKIP:  st_nx = D_OFFER;
            default: st_nx = D_OFFER;
        endcase
    end

    // Outputs
    always_comb begin
        offering = 1'b0;
        unique case (st)
            D_OFFER: offering = 1'b1;
            D_SKIP:  offering = 1'b0;
            default: offering = 1'b0;
        endcase
    end

    assign link_valid = offering ? gnt : '0;
    assign fire       = offering && any_rdy;

    // Raster coordinate, advanced on transfer only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x <= '0;
            cur_y <= '0;
        end else if (fire) begin
            if (cur_x == X_LAST) begin
                cur_x <= '0;
                cur_y <= (cur_y == Y_LAST) ? '0 : cur_y + 1'b1;
            end else begin
                cur_x <= cur_x + 1'b1;
            end
        end
    end

    AST_SINGLE_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(link_valid)); // R3
    AST_FIRE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ((link_valid & link_ready) != '0)); // R2
    AST_SKIP_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == D_OFFER && link_ready == '0) |=> !fire); // R4
    AST_HOLD_COORD: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable({cur_x, cur_y})); // R5
    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cur_x != X_LAST) |=> (cur_x == $past(cur_x) + 1'b1 && cur_y == $past(cur_y))); // R5
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cur_x == X_LAST && cur_y == Y_LAST) |=> (cur_x == '0 && cur_y == '0)); // R6

endmodule

// File: rtl/pd_worker.sv
module pd_worker
    import pd_pkg::*;
#(
    parameter int XW      = 2,
    parameter int YW      = 2,
    parameter int MIN_LAT = 3,
    parameter int MAX_LAT = 5,
    parameter int SEED    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [XW-1:0]    in_x,
    input  logic [YW-1:0]    in_y,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_pix,
    output logic [XW-1:0]    out_x,
    output logic [YW-1:0]    out_y
);

    localparam int SPAN = MAX_LAT - MIN_LAT + 1;
    localparam int CW   = $clog2(MAX_LAT + 1);
    localparam int LW   = 4;

    wstate_e        st, st_nx;
    logic [CW-1:0]  cnt;
    logic [LW-1:0]  lfsr;
    logic [CW-1:0]  cnt_init;

    assign cnt_init = CW'(MIN_LAT - 2 + (int'(lfsr) % SPAN));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= W_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            W_IDLE:  if (in_valid)  st_nx = W_BUSY;
            W_BUSY:  if (cnt == '0) st_nx = W_DONE;
            W_DONE:  if (out_ready) st_nx = W_IDLE;
            default: st_nx = W_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (st)
            W_IDLE:  in_ready  = 1'b1;
            W_BUSY:  ;
            W_DONE:  out_valid = 1'b1;
            default: ;
        endcase
    end

    // Item capture, latency counter and latency generator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            lfsr    <= LW'(SEED);
            out_pix <= '0;
            out_x   <= '0;
            out_y   <= '0;
        end else if (st == W_IDLE && in_valid) begin
            cnt     <= cnt_init;
            lfsr    <= {lfsr[LW-2:0], lfsr[LW-1] ^ lfsr[LW-2]};
            out_pix <= pix_class(in_x[0], in_y[0]);
            out_x   <= in_x;
            out_y   <= in_y;
        end else if (st == W_BUSY && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> in_ready); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_BUSY) |-> (int'(cnt) <= MAX_LAT - 2)); // R1
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix))); // R8

endmodule

// File: rtl/pixel_dispatch_top.sv
module pixel_dispatch_top
    import pd_pkg::*;
#(
    parameter int NUM_WORKERS = 5,
    parameter int SCR_W       = 4,
    parameter int SCR_H       = 4,
    parameter int MIN_LAT     = 3,
    parameter int MAX_LAT     = 5,
    localparam int XW    = (SCR_W > 1) ? $clog2(SCR_W) : 1,
    localparam int YW    = (SCR_H > 1) ? $clog2(SCR_H) : 1,
    localparam int IDX_W = (NUM_WORKERS > 1) ? $clog2(NUM_WORKERS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_WORKERS-1:0]       res_ready,
    output logic                         disp_fire,
    output logic [IDX_W-1:0]             disp_worker,
    output logic [XW-1:0]                disp_x,
    output logic [YW-1:0]                disp_y,
    output logic [NUM_WORKERS-1:0]       res_valid,
    output logic [PIX_W*NUM_WORKERS-1:0] res_pix,
    output logic [XW*NUM_WORKERS-1:0]    res_x,
    output logic [YW*NUM_WORKERS-1:0]    res_y
);

    logic [NUM_WORKERS-1:0] link_valid;
    logic [NUM_WORKERS-1:0] link_ready;

    pd_dispatcher #(
        .N(NUM_WORKERS), .SCR_W(SCR_W), .SCR_H(SCR_H),
        .XW(XW), .YW(YW), .IDX_W(IDX_W)
    ) u_disp (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_ready (link_ready),
        .link_valid (link_valid),
        .fire       (disp_fire),
        .widx       (disp_worker),
        .cur_x      (disp_x),
        .cur_y      (disp_y)
    );

    for (genvar i = 0; i < NUM_WORKERS; i++) begin : g_worker
        pd_worker #(
            .XW(XW), .YW(YW), .MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT),
            .SEED((i % 15) + 1)
        ) u_worker (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (link_valid[i]),
            .in_ready  (link_ready[i]),
            .in_x      (disp_x),
            .in_y      (disp_y),
            .out_valid (res_valid[i]),
            .out_ready (res_ready[i]),
            .out_pix   (res_pix[i*PIX_W +: PIX_W]),
            .out_x     (res_x[i*XW +: XW]),
            .out_y     (res_y[i*YW +: YW])
        );
    end

endmodule

// File: tb/pixel_dispatch_top_tb.sv
module pixel_dispatch_top_tb;

    localparam int N   = 5;
    localparam int NPH = 8;

    typedef struct packed {
        logic [N-1:0] mask;
        logic [15:0]  lo;
        logic [15:0]  hi;
    } phase_t;

    // result-acceptance mask per phase, bounds on transfers in 60 cycles
    localparam phase_t TAB [NPH] = '{
        '{5'b11111, 16'd30, 16'd60},
        '{5'b00000, 16'd0,  16'd5 },
        '{5'b00001, 16'd5,  16'd60},
        '{5'b11110, 16'd20, 16'd60},
        '{5'b10101, 16'd10, 16'd60},
        '{5'b01010, 16'd5,  16'd60},
        '{5'b00000, 16'd0,  16'd5 },
        '{5'b11111, 16'd30, 16'd60}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   res_ready = '0;
    logic           disp_fire;
    logic [2:0]     disp_worker;
    logic [1:0]     disp_x, disp_y;
    logic [N-1:0]   res_valid;
    logic [2*N-1:0] res_pix, res_x, res_y;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int fire_cnt = 0;

    // bench model
    logic [N-1:0] m_busy;
    logic [N-1:0] m_seen;
    logic         m_offer;
    int           ex, ey;
    int           m_t  [N];
    int           m_x  [N];
    int           m_y  [N];

    always #4 clk = ~clk;

    pixel_dispatch_top u_dut (
        .clk(clk), .rst_n(rst_n), .res_ready(res_ready),
        .disp_fire(disp_fire), .disp_worker(disp_worker),
        .disp_x(disp_x), .disp_y(disp_y), .res_valid(res_valid),
        .res_pix(res_pix), .res_x(res_x), .res_y(res_y)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    function automatic int exp_class(input int x, input int y);
        if ((x % 2) == 0 && (y % 2) == 0) return 2;
        if ((x % 2) == 1 && (y % 2) == 1) return 1;
        return 3;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            m_busy  = '0;
            m_seen  = '0;
            m_offer = 1'b1;
            ex = 0;
            ey = 0;
        end else begin
            logic [N-1:0] free;
            bit   exp_fire;
            int   pick;
            free     = ~m_busy;
            exp_fire = m_offer && (free != '0);
            chk(disp_fire == exp_fire, "R4 transfer/skip", int'(disp_fire), int'(exp_fire));
            // results: latency, hold and class
            for (int i = 0; i < N; i++) begin
                if (res_valid[i] && !m_busy[i])
                    chk(1'b0, "R8 result without item", 1, 0);
                if (res_valid[i] && m_busy[i] && !m_seen[i]) begin
                    chk((cyc - m_t[i]) >= 3 && (cyc - m_t[i]) <= 5, "R1 latency", cyc - m_t[i], 4);
                    m_seen[i] = 1'b1;
                end
                if (!res_valid[i] && m_seen[i])
                    chk(1'b0, "R8 result dropped", 0, 1);
                if (res_valid[i] && res_ready[i] && m_busy[i]) begin
                    chk(int'(res_pix[2*i +: 2]) == exp_class(m_x[i], m_y[i]), "R7 class",
                        int'(res_pix[2*i +: 2]), exp_class(m_x[i], m_y[i]));
                    chk(int'(res_x[2*i +: 2]) == m_x[i] && int'(res_y[2*i +: 2]) == m_y[i],
                        "R7 coordinate", int'(res_x[2*i +: 2]) * 4 + int'(res_y[2*i +: 2]),
                        m_x[i] * 4 + m_y[i]);
                    m_busy[i] = 1'b0;
                    m_seen[i] = 1'b0;
                end
            end
            if (exp_fire) begin
                pick = -1;
                for (int i = N - 1; i >= 0; i--) if (free[i]) pick = i;
                chk(int'(disp_worker) == pick, "R3 lowest ready", int'(disp_worker), pick);
                chk(int'(disp_x) == ex && int'(disp_y) == ey, "R6 raster order",
                    int'(disp_y) * 4 + int'(disp_x), ey * 4 + ex);
                m_busy[pick] = 1'b1;
                m_t[pick] = cyc;
                m_x[pick] = ex;
                m_y[pick] = ey;
                fire_cnt++;
                if (ex == 3) begin
                    ex = 0;
                    ey = (ey == 3) ? 0 : ey + 1;
                end else begin
                    ex = ex + 1;
                end
            end else begin
                chk(int'(disp_x) == ex && int'(disp_y) == ey, "R5 coordinate held",
                    int'(disp_y) * 4 + int'(disp_x), ey * 4 + ex);
            end
            m_offer = exp_fire ? 1'b1 : !m_offer;
        end
        cyc++;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(disp_x == 2'd0 && disp_y == 2'd0, "R9 reset coordinate", int'({disp_y, disp_x}), 0);
        chk(res_valid == '0, "R9 reset results", int'(res_valid), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        for (int p = 0; p < NPH; p++) begin
            @(posedge clk);
            #1 res_ready = TAB[p].mask;
            fire_cnt = 0;
            repeat (60) @(posedge clk);
            chk(fire_cnt >= int'(TAB[p].lo) && fire_cnt <= int'(TAB[p].hi),
                "R2 transfers per phase", fire_cnt, int'(TAB[p].lo));
        end

        // reset in the middle of a frame
        @(posedge clk);
        #1 rst_n = 1'b0;
        res_ready = '1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(disp_x == 2'd0 && disp_y == 2'd0, "R9 mid-run reset coordinate", int'({disp_y, disp_x}), 0);
        chk(res_valid == '0, "R9 mid-run reset results", int'(res_valid), 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(disp_fire == 1'b1 && disp_worker == 3'd0, "R9 first offer to unit 0",
            int'(disp_worker), 0);
        repeat (40) @(posedge clk);

        // only unit 4 frees: every transfer after the stall goes to it
        #1 res_ready = 5'b10000;
        repeat (80) @(posedge clk);
        #1 res_ready = '1;
        repeat (40) @(posedge clk);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule